// File: doc/BRIEF.md
# Instruction Operand Fault Screen

This block sits between operand fetch and execution in a word-oriented interpreter pipeline. On every accepted instruction it inspects the opcode and the two source operand words, along with the result exponent that the arithmetic unit predicts. From these it decides whether the instruction must trap, and why. Faults are detected from the data encodings themselves, not from arithmetic exception flags. A word that holds only the sign bit marks a variable that was never written. A zero exponent field marks a denormal floating-point operand.

Several conditions may hold at once. A fixed priority encoder reduces them to a single 3-bit cause. The cause and a fault flag are registered, so they appear one clock after the instruction is presented. The downstream trap logic uses the cause to pick a handler. The fuzzy floating-point compare, the trap handler and the arithmetic itself lie outside this block.

Top module: `opfault_screen`

## Requirements
- R1: Opcodes 0x00 and 0x40 are illegal, so that a word of all zeros or a negative-zero word trap when executed. Either one gives cause 1 (illegal opcode).
- R2: Opcodes 0x3D to 0x3F, 0x47 and 0x4E to 0x7F are also illegal and give cause 1. Every other 7-bit opcode is legal, for example 0x01, 0x3C, 0x46 and 0x4D.
- R3: An operand equal to 64'h8000_0000_0000_0000 (bit 63 set, all other bits clear) is uninitialized. When B is uninitialized the cause is 2; when C is uninitialized the cause is 3. These checks apply whether or not the opcode is floating point. A word with any other bit set, and plain zero, are not uninitialized.
- R4: When is_float_i is 1 and bits 63:52 of B are all zero, the cause is 4 (unnormalized B). When is_float_i is 0, the exponent field of B is ignored.
- R5: When is_float_i is 1 and res_exp_i is greater than 1023, the cause is 5 (overflow). A value of exactly 1023 is not an overflow. When is_float_i is 0, res_exp_i is ignored.
- R6: When several conditions hold, the reported cause follows this order, highest first: illegal opcode (1), uninitialized B (2), uninitialized C (3), unnormalized B (4), overflow (5).
- R7: cause_o and fault_o are registered. They reflect the instruction presented at the previous rising clock edge. fault_o is 1 exactly when cause_o is nonzero, and cause 0 means no fault.
- R8: When valid_i is 0 at a clock edge, the next outputs are cause 0 and fault_o 0, whatever the other inputs hold.
- R9: A synchronous active-high reset drives cause_o to 0 and fault_o to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 7 | Opcode of the instruction |
| is_float_i | input | 1 | The opcode is a floating-point operation |
| b_i | input | 64 | Value of source operand B |
| c_i | input | 64 | Value of source operand C |
| res_exp_i | input | 12 | Result exponent predicted by the arithmetic unit |
| fault_o | output | 1 | Registered fault flag |
| cause_o | output | 3 | Registered fault cause; 0 means no fault |

## Verification
The hardest situation to reach is one where several fault conditions hold in the same cycle. Only then does the priority order show, and a single-fault test cannot separate a correct encoder from one with two branches swapped. The vector table therefore stacks faults in pairs and triples, for example an illegal opcode with an uninitialized B. It also includes near misses: a sign-only word with the lowest bit set, a result exponent of exactly 1023, and integer opcodes carrying float-fault patterns. Directed steps then sweep all 128 opcodes, apply reset while a fault is being reported, and drop valid while faulty inputs are held.

// File: rtl/opfault_pkg.sv
package opfault_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_ILLEGAL_OP = 3'd1,
    CAUSE_UNINIT_B   = 3'd2,
    CAUSE_UNINIT_C   = 3'd3,
    CAUSE_UNNORM_B   = 3'd4,
    CAUSE_OVERFLOW   = 3'd5
  } cause_e;
endpackage

// File: rtl/opf_opcode_screen.sv
module opf_opcode_screen #(
  parameter int OP_W        = 7,
  parameter int HOLE_LO     = 'h3D,
  parameter int HOLE_HI     = 'h3F,
  parameter int SINGLE_HOLE = 'h47,
  parameter int TOP_FREE_LO = 'h4E
) (
  input  logic [OP_W-1:0] op,
  output logic            illegal
);
  // Zero word and sign-only word both trap when executed
  localparam logic [OP_W-1:0] ZERO_TRAP = '0;
  localparam logic [OP_W-1:0] NEGZ_TRAP = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [OP_W-1:0] H_LO      = OP_W'(HOLE_LO);
  localparam logic [OP_W-1:0] H_HI      = OP_W'(HOLE_HI);
  localparam logic [OP_W-1:0] H_ONE     = OP_W'(SINGLE_HOLE);
  localparam logic [OP_W-1:0] T_LO      = OP_W'(TOP_FREE_LO);

  always_comb begin
    illegal = 1'b0;
    if (op == ZERO_TRAP || op == NEGZ_TRAP) illegal = 1'b1;
    if (op >= H_LO && op <= H_HI)           illegal = 1'b1;
    if (op == H_ONE)                        illegal = 1'b1;
    if (op >= T_LO)                         illegal = 1'b1;
  end
endmodule

// File: rtl/opf_word_screen.sv
module opf_word_screen #(
  parameter int WORD_W = 64,
  parameter int EXP_W  = 12
) (
  input  logic [WORD_W-1:0] word,
  output logic              neg_zero,
  output logic              exp_zero
);
  localparam logic [WORD_W-1:0] SIGN_ONLY = {1'b1, {(WORD_W-1){1'b0}}};

  assign neg_zero = (word == SIGN_ONLY);
  assign exp_zero = (word[WORD_W-1 -: EXP_W] == '0);
endmodule

// File: rtl/opf_fault_prio.sv
module opf_fault_prio
  import opfault_pkg::*;
(
  input  logic   illegal,
  input  logic   uninit_b,
  input  logic   uninit_c,
  input  logic   unnorm_b,
  input  logic   overflow,
  output cause_e cause
);
  always_comb begin
    if (illegal)       cause = CAUSE_ILLEGAL_OP;
    else if (uninit_b) cause = CAUSE_UNINIT_B;
    else if (uninit_c) cause = CAUSE_UNINIT_C;
    else if (unnorm_b) cause = CAUSE_UNNORM_B;
    else if (overflow) cause = CAUSE_OVERFLOW;
    else               cause = CAUSE_NONE;
  end
endmodule

// File: rtl/opfault_screen.sv
module opfault_screen
  import opfault_pkg::*;
#(
  parameter int OP_W      = 7,
  parameter int WORD_W    = 64,
  parameter int EXP_W     = 12,
  parameter int RES_W     = 12,
  parameter int OVF_LIMIT = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              is_float_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] c_i,
  input  logic [RES_W-1:0]  res_exp_i,
  output logic              fault_o,
  output logic [2:0]        cause_o
);
  localparam int              N_SRC   = 2;
  localparam logic [RES_W-1:0] OVF_LIM = RES_W'(OVF_LIMIT);

  logic              illegal;
  logic [WORD_W-1:0] src [N_SRC];
  logic [N_SRC-1:0]  src_nz;
  logic [N_SRC-1:0]  src_ez;
  logic              ovf;
  cause_e            cause_d;
  cause_e            cause_q;
  logic              fault_q;

  assign src[0] = b_i;
  assign src[1] = c_i;

  opf_opcode_screen #(.OP_W(OP_W)) u_opcode (
    .op      (opcode_i),
    .illegal (illegal)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    opf_word_screen #(.WORD_W(WORD_W), .EXP_W(EXP_W)) u_word (
      .word     (src[s]),
      .neg_zero (src_nz[s]),
      .exp_zero (src_ez[s])
    );
  end

  assign ovf = is_float_i && (res_exp_i > OVF_LIM);

  opf_fault_prio u_prio (
    .illegal  (illegal),
    .uninit_b (src_nz[0]),
    .uninit_c (src_nz[1]),
    .unnorm_b (is_float_i && src_ez[0]),
    .overflow (ovf),
    .cause    (cause_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CAUSE_NONE;
      fault_q <= 1'b0;
    end else if (valid_i) begin
      cause_q <= cause_d;
      fault_q <= (cause_d != CAUSE_NONE);
    end else begin
      cause_q <= CAUSE_NONE;
      fault_q <= 1'b0;
    end
  end

  assign cause_o = cause_q;
  assign fault_o = fault_q;

  // R1/R2/R6: an illegal opcode outranks everything one cycle later
  p_illegal_first_r1: assert property (@(posedge clk) disable iff (rst)
    valid_i && illegal |=> cause_o == CAUSE_ILLEGAL_OP);

  // R3: sign-only B on a legal opcode reports uninitialized B
  p_uninit_b_r3: assert property (@(posedge clk) disable iff (rst)
    valid_i && !illegal && src_nz[0] |=> cause_o == CAUSE_UNINIT_B);

  // R4: integer ops with clean operands never fault
  p_int_clean_r4: assert property (@(posedge clk) disable iff (rst)
    valid_i && !is_float_i && !illegal && src_nz == '0 |=> !fault_o);

  // R5: exponent above limit on otherwise clean float op
  p_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_float_i && !illegal && src_nz == '0 && !src_ez[0]
    && res_exp_i > OVF_LIM |=> cause_o == CAUSE_OVERFLOW);

  // R7: flag and cause agree
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (rst)
    fault_o == (cause_o != 3'd0));

  // R8: idle cycle yields no fault
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !fault_o && cause_o == 3'd0);

  // R9: reset clears the outputs
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !fault_o && cause_o == 3'd0);
endmodule

// File: tb/test_opfault_screen.sv
module test_opfault_screen;
  localparam logic [63:0] GOOD = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DEN  = 64'h000F_0000_0000_1234;
  localparam int NV = 24;
  // {opcode, is_float, B, C, res_exp, expected cause}
  localparam logic [150:0] VECS [NV] = '{
    {7'h01, 1'b0, GOOD, GOOD, 12'd0,    3'd0},
    {7'h00, 1'b0, GOOD, GOOD, 12'd0,    3'd1},
    {7'h40, 1'b0, GOOD, GOOD, 12'd0,    3'd1},
    {7'h3D, 1'b0, GOOD, GOOD, 12'd0,    3'd1},
    {7'h47, 1'b0, GOOD, GOOD, 12'd0,    3'd1},
    {7'h4E, 1'b0, GOOD, GOOD, 12'd0,    3'd1},
    {7'h7F, 1'b1, GOOD, GOOD, 12'd0,    3'd1},
    {7'h3C, 1'b0, GOOD, GOOD, 12'd0,    3'd0},
    {7'h4D, 1'b1, GOOD, GOOD, 12'd500,  3'd0},
    {7'h46, 1'b1, GOOD, GOOD, 12'd500,  3'd0},
    {7'h01, 1'b0, NZ,   GOOD, 12'd0,    3'd2},
    {7'h01, 1'b0, GOOD, NZ,   12'd0,    3'd3},
    {7'h11, 1'b1, DEN,  GOOD, 12'd500,  3'd4},
    {7'h11, 1'b1, GOOD, GOOD, 12'd1024, 3'd5},
    {7'h11, 1'b1, GOOD, GOOD, 12'd1023, 3'd0},
    {7'h01, 1'b0, DEN,  GOOD, 12'd0,    3'd0},
    {7'h01, 1'b0, GOOD, GOOD, 12'd4095, 3'd0},
    {7'h00, 1'b1, NZ,   NZ,   12'd4095, 3'd1},
    {7'h01, 1'b0, NZ,   NZ,   12'd0,    3'd2},
    {7'h11, 1'b1, DEN,  NZ,   12'd2000, 3'd3},
    {7'h11, 1'b1, DEN,  GOOD, 12'd2000, 3'd4},
    {7'h01, 1'b0, NZ | 64'd1, GOOD, 12'd0, 3'd0},
    {7'h01, 1'b0, GOOD, 64'd0, 12'd0,   3'd0},
    {7'h11, 1'b1, 64'd0, GOOD, 12'd100, 3'd4}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [6:0]  opcode_i;
  logic        is_float_i;
  logic [63:0] b_i;
  logic [63:0] c_i;
  logic [11:0] res_exp_i;
  logic        fault_o;
  logic [2:0]  cause_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  opfault_screen i_opfault_screen (
    .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
    .is_float_i(is_float_i), .b_i(b_i), .c_i(c_i), .res_exp_i(res_exp_i),
    .fault_o(fault_o), .cause_o(cause_o)
  );

  task automatic check(input logic [2:0] exp_cause, input string req);
    n_checks++;
    if (cause_o !== exp_cause || fault_o !== (exp_cause != 3'd0)) begin
      n_fail++;
      $display("FAIL %s: cause=%0d fault=%0b expected cause=%0d fault=%0b",
               req, cause_o, fault_o, exp_cause, exp_cause != 3'd0);
    end
  endtask

  task automatic drive(input logic [6:0] op, input logic fl,
                       input logic [63:0] b, input logic [63:0] c,
                       input logic [11:0] e);
    @(negedge clk);
    valid_i = 1'b1; opcode_i = op; is_float_i = fl;
    b_i = b; c_i = c; res_exp_i = e;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; valid_i = 1'b0; opcode_i = '0; is_float_i = 1'b0;
    b_i = GOOD; c_i = GOOD; res_exp_i = '0;
    repeat (3) @(negedge clk);
    check(3'd0, "R9 reset state");
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][150:144], VECS[i][143], VECS[i][142:79],
            VECS[i][78:15], VECS[i][14:3]);
      check(VECS[i][2:0], $sformatf("R6 vector %0d", i));
    end

    // R2: every opcode with clean integer operands
    for (int op = 0; op < 128; op++) begin
      logic bad;
      bad = (op == 0) || (op == 'h40) || (op >= 'h3D && op <= 'h3F) ||
            (op == 'h47) || (op >= 'h4E);
      drive(7'(op), 1'b0, GOOD, GOOD, 12'd0);
      check(bad ? 3'd1 : 3'd0, $sformatf("R2 opcode %0h", op));
    end

    // R8: valid low with every fault present
    drive(7'h00, 1'b1, NZ, NZ, 12'd4000);
    check(3'd1, "R1 before idle");
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    check(3'd0, "R8 idle with faulty inputs");

    // R9: reset while a fault is reported
    drive(7'h01, 1'b0, NZ, GOOD, 12'd0);
    check(3'd2, "R3 before reset");
    rst = 1'b1;
    @(negedge clk);
    check(3'd0, "R9 reset during fault");
    rst = 1'b0;

    // R7: one-cycle latency, change visible only after the edge
    drive(7'h11, 1'b1, GOOD, GOOD, 12'd3000);
    check(3'd5, "R7 latency overflow");
    @(negedge clk); opcode_i = 7'h40;
    @(posedge clk); #1;
    n_checks++;
    if (cause_o !== 3'd1) begin
      n_fail++;
      $display("FAIL R7: cause=%0d expected 1", cause_o);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule